// File: doc/BRIEF.md
# Pad Function Controller with Pulsed Interrupt

This block sets what each of three general-purpose pads on a receiver chip does. A 2-bit mode code chooses one of four pad behaviours: high impedance, the pad's own alternate function, a forced low or a forced high. Pad 1 has no alternate function. Pad 2's alternate function is an active-low interrupt. Pad 3's alternate function shows whether the receiver is in stereo.

The interrupt is a low pulse with a fixed width. It starts when a seek/tune-complete event or a data-ready event arrives and that event's own enable is set. A new event during a pulse restarts the width count, so the pulse ends a full width after the latest event. The mode codes and the enables are registered. The event strobes are sampled on the clock. The stereo status passes straight through to the pad.

The register bus that writes the fields is outside this block. So are the pad cells that take the value and enable outputs.

Top module: `gpio_pin_ctrl`

## Requirements
- R1: After reset, every pad has its output enable low and no interrupt pulse is active. Every enable register is also cleared.
- R2: The mode codes and the interrupt enables are registered. A change at an input takes effect at the first rising edge that samples it.
- R3: Mode code 2'b00 on any pad drives its output enable low.
- R4: Mode code 2'b10 drives the pad low with its output enable high.
- R5: Mode code 2'b11 drives the pad high with its output enable high.
- R6: On pad 1, mode code 2'b01 is reserved and acts as high impedance: output enable low.
- R7: On pad 2, mode code 2'b01 drives the pad with output enable high. The pad is high when no pulse is active and low while a pulse is active.
- R8: A seek/tune-complete strobe sampled at a rising edge, with its enable already registered as 1, makes the interrupt active for exactly PULSE_W cycles starting at that edge. PULSE_W defaults to 4.
- R9: A data-ready strobe starts the same pulse under its own separate enable.
- R10: A strobe whose enable is registered as 0 has no effect on the interrupt.
- R11: A qualified strobe during an active pulse extends it. The pulse ends PULSE_W cycles after the edge that sampled the latest strobe.
- R12: On pad 3, mode code 2'b01 drives the stereo status input onto the pad with output enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_mode_i | input | 6 | Mode codes, bits [2k+1:2k] for pad k+1 |
| stc_ien_i | input | 1 | Interrupt enable for seek/tune-complete |
| rdy_ien_i | input | 1 | Interrupt enable for data-ready |
| stc_evt_i | input | 1 | Seek/tune-complete strobe |
| rdy_evt_i | input | 1 | Data-ready strobe |
| stereo_i | input | 1 | Stereo status, 1 = stereo |
| pad_o | output | 3 | Pad output values, bit k for pad k+1 |
| pad_oe_o | output | 3 | Pad output enables, bit k for pad k+1 |

## Verification
The assertions assume two things about the inputs. First, the mode and enable inputs hold steady during reset, because the properties compare outputs with the input values registered one edge earlier. Second, every strobe is a clean synchronous level at each edge. The stimulus keeps to both: it holds every input at zero while reset is low, and it changes inputs only on falling edges. Random strobes and enable toggles land on every phase of an active pulse, which exercises the retrigger case. Directed runs cover back-to-back events and events whose enable is cleared.

// File: rtl/gpio_pin_ctrl_pkg.sv
package gpio_pin_ctrl_pkg;
  localparam int unsigned NUM_PADS = 3;

  typedef enum logic [1:0] {
    PM_HIZ  = 2'b00,
    PM_ALT  = 2'b01,
    PM_LOW  = 2'b10,
    PM_HIGH = 2'b11
  } pad_mode_e;
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_pin_ctrl_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [2*NUM_PADS-1:0] pin_mode_i,
  input  logic                  stc_ien_i,
  input  logic                  rdy_ien_i,
  output logic [2*NUM_PADS-1:0] pin_mode_q_o,
  output logic                  stc_ien_q_o,
  output logic                  rdy_ien_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_mode_q_o <= '0;
      stc_ien_q_o  <= 1'b0;
      rdy_ien_q_o  <= 1'b0;
    end else begin
      pin_mode_q_o <= pin_mode_i;
      stc_ien_q_o  <= stc_ien_i;
      rdy_ien_q_o  <= rdy_ien_i;
    end
  end
endmodule

// File: rtl/gpio_irq_pulse.sv
module gpio_irq_pulse #(
  parameter int unsigned PULSE_W = 4,
  localparam int unsigned CNT_W  = $clog2(PULSE_W + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stc_ien_q_i,
  input  logic rdy_ien_q_i,
  input  logic stc_evt_i,
  input  logic rdy_evt_i,
  output logic irq_act_o
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_W);

  logic [CNT_W-1:0] cnt_q;
  logic             fire;

  assign fire = (stc_evt_i & stc_ien_q_i) | (rdy_evt_i & rdy_ien_q_i);

  // reload on every qualified event, so a retrigger extends the pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (fire)           cnt_q <= LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign irq_act_o = (cnt_q != '0);

  a_r8_stc_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stc_evt_i && stc_ien_q_i) |=> irq_act_o);
  a_r9_rdy_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_evt_i && rdy_ien_q_i) |=> irq_act_o);
  a_r10_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_act_o) |-> $past(fire));
  a_r11_full_after_evt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> (cnt_q == LOAD));
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
  import gpio_pin_ctrl_pkg::*;
#(
  parameter bit ALT_EN = 1'b1
) (
  input  logic [1:0] mode_i,
  input  logic       alt_i,
  output logic       pad_o,
  output logic       pad_oe_o
);
  always_comb begin
    unique case (pad_mode_e'(mode_i))
      PM_HIZ:  begin pad_oe_o = 1'b0;   pad_o = 1'b0;  end
      PM_ALT:  begin pad_oe_o = ALT_EN; pad_o = alt_i; end
      PM_LOW:  begin pad_oe_o = 1'b1;   pad_o = 1'b0;  end
      default: begin pad_oe_o = 1'b1;   pad_o = 1'b1;  end
    endcase
  end
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
  import gpio_pin_ctrl_pkg::*;
#(
  parameter int unsigned PULSE_W = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [2*NUM_PADS-1:0] pin_mode_i,
  input  logic                  stc_ien_i,
  input  logic                  rdy_ien_i,
  input  logic                  stc_evt_i,
  input  logic                  rdy_evt_i,
  input  logic                  stereo_i,
  output logic [NUM_PADS-1:0]   pad_o,
  output logic [NUM_PADS-1:0]   pad_oe_o
);
  logic [2*NUM_PADS-1:0] mode_q;
  logic                  stc_ien_q, rdy_ien_q;
  logic                  irq_act;
  logic [NUM_PADS-1:0]   alt_fn;

  gpio_cfg_regs u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pin_mode_i   (pin_mode_i),
    .stc_ien_i    (stc_ien_i),
    .rdy_ien_i    (rdy_ien_i),
    .pin_mode_q_o (mode_q),
    .stc_ien_q_o  (stc_ien_q),
    .rdy_ien_q_o  (rdy_ien_q)
  );

  gpio_irq_pulse #(.PULSE_W(PULSE_W)) u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stc_ien_q_i (stc_ien_q),
    .rdy_ien_q_i (rdy_ien_q),
    .stc_evt_i   (stc_evt_i),
    .rdy_evt_i   (rdy_evt_i),
    .irq_act_o   (irq_act)
  );

  // pad1: reserved alt, pad2: active-low interrupt, pad3: stereo flag
  assign alt_fn = {stereo_i, ~irq_act, 1'b0};

  for (genvar k = 0; k < NUM_PADS; k++) begin : g_pad
    gpio_pad_mux #(.ALT_EN(k != 0)) u_mux (
      .mode_i   (mode_q[2*k +: 2]),
      .alt_i    (alt_fn[k]),
      .pad_o    (pad_o[k]),
      .pad_oe_o (pad_oe_o[k])
    );

    a_r3_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(pin_mode_i[2*k +: 2]) == 2'b00) |-> !pad_oe_o[k]);
    a_r4_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(pin_mode_i[2*k +: 2]) == 2'b10) |-> (pad_oe_o[k] && !pad_o[k]));
    a_r5_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(pin_mode_i[2*k +: 2]) == 2'b11) |-> (pad_oe_o[k] && pad_o[k]));
  end

  a_r6_pad1_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(pin_mode_i[1:0]) == 2'b01) |-> !pad_oe_o[0]);
  a_r7_irq_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(pin_mode_i[3:2]) == 2'b01) |-> (pad_oe_o[1] && (pad_o[1] == !irq_act)));
endmodule

// File: tb/gpio_pin_ctrl_tb_top.sv
module gpio_pin_ctrl_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  PW = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] mode = '0;
  logic       stc_ien = 0, rdy_ien = 0, stc_evt = 0, rdy_evt = 0, stereo = 0;
  logic [2:0] pad, pad_oe;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference state
  logic [5:0] m_mode = '0;
  logic       m_stc_en = 0, m_rdy_en = 0;
  int         m_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_pin_ctrl #(.PULSE_W(PW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pin_mode_i(mode),
    .stc_ien_i(stc_ien), .rdy_ien_i(rdy_ien),
    .stc_evt_i(stc_evt), .rdy_evt_i(rdy_evt), .stereo_i(stereo),
    .pad_o(pad), .pad_oe_o(pad_oe)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode <= '0; m_stc_en <= 0; m_rdy_en <= 0; m_cnt <= 0;
    end else begin
      m_mode   <= mode;
      m_stc_en <= stc_ien;
      m_rdy_en <= rdy_ien;
      if ((stc_evt && m_stc_en) || (rdy_evt && m_rdy_en)) m_cnt <= PW;
      else if (m_cnt > 0) m_cnt <= m_cnt - 1;
    end
  end

  function automatic bit exp_oe(int k, logic [1:0] md);
    return (md != 2'b00) && !(k == 0 && md == 2'b01);
  endfunction

  function automatic bit exp_val(int k, logic [1:0] md, bit act, bit st);
    case (md)
      2'b10: return 1'b0;
      2'b11: return 1'b1;
      2'b01: return (k == 1) ? !act : st;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(int k, logic [1:0] md);
    case (md)
      2'b00: return "R3";
      2'b10: return "R4";
      2'b11: return "R5";
      default: return (k == 0) ? "R6" : (k == 1) ? "R7" : "R12";
    endcase
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d @%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_pads(string tag);
    for (int k = 0; k < 3; k++) begin
      logic [1:0] md = m_mode[2*k +: 2];
      string t = (tag.len() != 0) ? tag : tag_of(k, md);
      chk(t, $sformatf("pad%0d oe", k+1), int'(pad_oe[k]), int'(exp_oe(k, md)));
      if (exp_oe(k, md))
        chk(t, $sformatf("pad%0d val", k+1), int'(pad[k]),
            int'(exp_val(k, md, m_cnt > 0, stereo)));
    end
  endtask

  task automatic step(logic [5:0] md, bit se, bit re, bit sv, bit rv, bit st, string tag);
    @(negedge clk);
    mode = md; stc_ien = se; rdy_ien = re; stc_evt = sv; rdy_evt = rv; stereo = st;
    @(posedge clk); #1;
    check_pads(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    #(CLK_PERIOD * 3 + 2);
    // R1: reset state
    chk("R1", "oe after reset", int'(pad_oe), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", "oe after release", int'(pad_oe), 0);

    // R2: registered mode takes effect at the sampling edge, not before
    @(negedge clk); mode = 6'b11_10_11;
    #1 chk("R2", "oe before edge", int'(pad_oe), 0);
    @(posedge clk); #1;
    chk("R2", "oe after edge", int'(pad_oe), 7);
    check_pads("R2");

    // pad2 interrupt, pad3 stereo, pad1 reserved
    step(6'b01_01_01, 1, 0, 0, 0, 1, "");
    step(6'b01_01_01, 1, 0, 0, 0, 0, "R12");
    // R8: stc event -> exactly PW low cycles
    step(6'b01_01_01, 1, 0, 1, 0, 1, "R8");
    chk("R8", "pad2 low at start", int'(pad[1]), 0);
    for (int i = 1; i < PW; i++) step(6'b01_01_01, 1, 0, 0, 0, 1, "R8");
    chk("R8", "pad2 still low last cycle", int'(pad[1]), 0);
    step(6'b01_01_01, 1, 0, 0, 0, 1, "R8");
    chk("R8", "pad2 released", int'(pad[1]), 1);

    // R10: disabled events ignored
    step(6'b01_01_01, 0, 0, 0, 0, 1, "R10");
    step(6'b01_01_01, 0, 0, 1, 1, 1, "R10");
    chk("R10", "pad2 idle", int'(pad[1]), 1);

    // R9: data-ready under its own enable; stc enable stays clear
    step(6'b01_01_01, 0, 1, 0, 0, 1, "R9");
    step(6'b01_01_01, 0, 1, 1, 0, 1, "R10");
    chk("R10", "stc with its enable clear", int'(pad[1]), 1);
    step(6'b01_01_01, 0, 1, 0, 1, 1, "R9");
    chk("R9", "pad2 low on rdy", int'(pad[1]), 0);

    // R11: retrigger mid-pulse extends to PW after the new event
    step(6'b01_01_01, 0, 1, 0, 0, 1, "R11");
    step(6'b01_01_01, 0, 1, 0, 1, 1, "R11");
    for (int i = 1; i < PW; i++) step(6'b01_01_01, 0, 1, 0, 0, 1, "R11");
    chk("R11", "pad2 low at extended end", int'(pad[1]), 0);
    step(6'b01_01_01, 0, 1, 0, 0, 1, "R11");
    chk("R11", "pad2 released after extension", int'(pad[1]), 1);

    // R2: enable registered; event in the same cycle as enable set is ignored
    step(6'b01_01_01, 0, 0, 0, 0, 1, "R2");
    step(6'b01_01_01, 1, 0, 1, 0, 1, "R2");
    chk("R2", "enable not yet active", int'(pad[1]), 1);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r = $urandom;
      step(r[5:0], r[6], r[7], (r[11:8] < 3), (r[15:12] < 3), r[16], "");
    end

    // R1: reset mid-pulse clears everything
    step(6'b01_01_01, 1, 1, 1, 1, 1, "R8");
    @(negedge clk); rst_n = 1'b0; mode = '0; stc_ien = 0; rdy_ien = 0; stc_evt = 0; rdy_evt = 0;
    #1 chk("R1", "oe in reset", int'(pad_oe), 0);
    @(negedge clk); rst_n = 1'b1;
    step(6'b00_01_00, 0, 0, 0, 0, 0, "R1");
    chk("R1", "pad2 idle after reset", int'(pad[1]), 1);

    finish_run();
  end
endmodule